// File: doc/BRIEF.md
# Binary Modular Exponentiation Engine

This block raises an unsigned base to an unsigned power modulo a third operand, with all three operands the same width `K`. The same hardware performs public-key encryption and decryption; the caller only changes which exponent is applied. The engine never forms the full power. Every intermediate value is reduced by the modulus as soon as it is produced.

The exponent is scanned from its most significant bit downward. The top bit chooses the starting accumulator: the base if the bit is set, otherwise one. Each of the remaining `K-1` bit positions then takes one modular squaring, followed by one modular multiply by the base when that bit is set. The loop always runs for `K-1` positions. Run time therefore depends only on how many multiplies occur, never on where the set bits sit.

Each modular product is formed by a sequential shift-and-add unit. It takes one multiplier bit per clock, starting at the MSB. After each add it makes at most two conditional subtractions of the modulus. The caller pulses `start` with the operands on the inputs. It then waits for the one-cycle `done` pulse and reads `result`, which holds until the next run ends. The base must be smaller than the modulus, and `K` must be at least 2.

Top module: `binexp_engine`

## Requirements
- R1: For any modulus n >= 2 and base m < n, the value on `result` when `done` pulses equals m^e mod n (for example 123^17 mod 3233 = 855 and 855^2753 mod 3233 = 123).
- R2: The accumulator starts at the base when exponent bit K-1 is 1 and at 1 otherwise, so e = 0 gives 1, e = 1 gives m, and e = 2^(K-1) gives m^(2^(K-1)) mod n.
- R3: An exponent with scattered set bits, such as 123 (binary 1111011), yields m^123 mod n through the chain m, m^3, m^7, m^15, m^30, m^61, m^123.
- R4: The cycle count from an accepted start to `done` is the same for any two exponents with the same number of ones in bits K-2..0. It grows by a fixed amount for each additional one.
- R5: `busy` is high in the cycle after an accepted start and stays high until the cycle in which `done` is high.
- R6: `done` is high for exactly one cycle per accepted start, with `busy` low. `result` changes only in a cycle where `done` is high and is stable otherwise.
- R7: A `start` pulse while `busy` is high is ignored: the running result is unaffected and no extra `done` follows.
- R8: A modulus of 1 gives `result` = 0 with `err` low.
- R9: A modulus of 0 gives `err` high and `result` = 0 within two cycles, with no iteration. The next run with a non-zero modulus clears `err`.
- R10: Operands are sampled at the accepted start; changing the inputs while busy has no effect on the result.
- R11: After reset `busy`, `done`, `err` and `result` are all 0.
- R12: Whenever `done` pulses with `err` low, `result` is below the captured modulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a run; accepted only while not busy |
| baseIn | input | K | Base, must be below the modulus |
| expIn | input | K | Exponent |
| modIn | input | K | Modulus |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | K | base^exp mod modulus, held until the next completion |
| err | output | 1 | Modulus was zero on the last accepted start |

## Verification
The bench aims at the two published key-pair vectors, at exponents of zero, one, top-bit-only and the 123 chain, and at random 16-bit operands checked against a repeated multiply-and-reduce model. A wrong initial-accumulator rule or an off-by-one loop count shows up as a wrong power on these exponents. A multiplier missing its second subtraction leaves values at or above n. The bench times runs whose exponents share a popcount but place their bits differently; a loop tied to the exponent's value gives unequal latencies. It also fires start mid-run and changes the inputs mid-run. Moduli of 0 and 1 are included, where a design without the special cases would hang, return 1, or leave the error flag stuck.

// File: rtl/binexp_pkg.sv
package binexp_pkg;

  typedef struct packed {
    logic capture;   // sample operands
    logic accInit;   // acc <= top exponent bit ? base : 1
    logic accZero;   // acc <= 0 (degenerate modulus)
    logic mulGo;     // launch a modular product
    logic mulBase;   // 1: acc*base, 0: acc*acc
    logic accTake;   // acc <= finished product
    logic expShift;  // move to next exponent bit
    logic outLatch;  // copy acc to result
  } dpCtl_t;

  typedef enum logic [2:0] {
    S_IDLE, S_SQ, S_SQW, S_MU, S_MUW, S_FIN
  } engState_t;

endpackage

// File: rtl/binexp_mulmod.sv
module binexp_mulmod #(
  parameter int K = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [K-1:0] opA,
  input  logic [K-1:0] opB,
  input  logic [K-1:0] modN,
  output logic         fin,
  output logic [K-1:0] prodNext
);
  localparam int CW = (K > 2) ? $clog2(K) : 1;
  localparam int WW = K + 2;

  logic [K-1:0]  partial, aReg, bReg;
  logic [CW-1:0] bitCnt;
  logic          running;
  logic [WW-1:0] shifted, once, twice, nWide;

  always_comb begin
    nWide   = {2'b00, modN};
    shifted = {1'b0, partial, 1'b0} + (bReg[K-1] ? {2'b00, aReg} : '0);
    once    = (shifted >= nWide) ? shifted - nWide : shifted;
    twice   = (once >= nWide) ? once - nWide : once;
    prodNext = twice[K-1:0];
  end

  assign fin = running && (bitCnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      partial <= '0;
      aReg    <= '0;
      bReg    <= '0;
      bitCnt  <= '0;
      running <= 1'b0;
    end else if (go) begin
      partial <= '0;
      aReg    <= opA;
      bReg    <= opB;
      bitCnt  <= CW'(K - 1);
      running <= 1'b1;
    end else if (running) begin
      partial <= prodNext;
      bReg    <= bReg << 1;
      if (bitCnt == '0) running <= 1'b0;
      else              bitCnt  <= bitCnt - 1'b1;
    end
  end
endmodule

// File: rtl/binexp_dp.sv
module binexp_dp
  import binexp_pkg::*;
#(
  parameter int K = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  dpCtl_t       ctl,
  input  logic [K-1:0] baseIn,
  input  logic [K-1:0] expIn,
  input  logic [K-1:0] modIn,
  output logic         modZeroIn,
  output logic         modOneIn,
  output logic         curBit,
  output logic         mulDone,
  output logic [K-1:0] result,
  output logic [K-1:0] modHeld,
  output logic         err
);
  logic [K-1:0] baseReg, expReg, modReg, acc, resReg, prodNext, mulA;
  logic         errReg;

  assign modZeroIn = (modIn == '0);
  assign modOneIn  = (modIn == K'(1));
  assign curBit    = expReg[K-2];
  assign mulA      = ctl.mulBase ? baseReg : acc;
  assign result    = resReg;
  assign modHeld   = modReg;
  assign err       = errReg;

  binexp_mulmod #(.K(K)) u_mm (
    .clk(clk), .rst(rst), .go(ctl.mulGo),
    .opA(mulA), .opB(acc), .modN(modReg),
    .fin(mulDone), .prodNext(prodNext)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      baseReg <= '0;
      expReg  <= '0;
      modReg  <= '0;
      acc     <= '0;
      resReg  <= '0;
      errReg  <= 1'b0;
    end else begin
      if (ctl.capture) begin
        baseReg <= baseIn;
        expReg  <= expIn;
        modReg  <= modIn;
        errReg  <= modZeroIn;
      end
      if (ctl.accZero)       acc <= '0;
      else if (ctl.accInit)  acc <= expIn[K-1] ? baseIn : K'(1);
      else if (ctl.accTake)  acc <= prodNext;
      if (ctl.expShift) expReg <= expReg << 1;
      if (ctl.outLatch) resReg <= acc;
    end
  end
endmodule

// File: rtl/binexp_ctrl.sv
module binexp_ctrl
  import binexp_pkg::*;
#(
  parameter int K = 16
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  input  logic   modZeroIn,
  input  logic   modOneIn,
  input  logic   curBit,
  input  logic   mulDone,
  output dpCtl_t ctl,
  output logic   busy,
  output logic   done
);
  localparam int SW = (K > 2) ? $clog2(K) : 1;

  engState_t     state, nextState;
  logic [SW-1:0] stepCnt;
  logic          lastStep, doneReg;

  assign lastStep = (stepCnt == '0);
  assign busy     = (state != S_IDLE);
  assign done     = doneReg;

  always_comb begin
    ctl       = '0;
    nextState = state;
    unique case (state)
      S_IDLE: if (start) begin
        ctl.capture = 1'b1;
        if (modZeroIn || modOneIn) begin
          ctl.accZero = 1'b1;
          nextState   = S_FIN;
        end else begin
          ctl.accInit = 1'b1;
          nextState   = S_SQ;
        end
      end
      S_SQ: begin
        ctl.mulGo = 1'b1;
        nextState = S_SQW;
      end
      S_SQW: if (mulDone) begin
        ctl.accTake = 1'b1;
        if (curBit)        nextState = S_MU;
        else if (lastStep) nextState = S_FIN;
        else begin
          ctl.expShift = 1'b1;
          nextState    = S_SQ;
        end
      end
      S_MU: begin
        ctl.mulGo   = 1'b1;
        ctl.mulBase = 1'b1;
        nextState   = S_MUW;
      end
      S_MUW: if (mulDone) begin
        ctl.accTake = 1'b1;
        if (lastStep) nextState = S_FIN;
        else begin
          ctl.expShift = 1'b1;
          nextState    = S_SQ;
        end
      end
      S_FIN: begin
        ctl.outLatch = 1'b1;
        nextState    = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      stepCnt <= '0;
      doneReg <= 1'b0;
    end else begin
      state   <= nextState;
      doneReg <= ctl.outLatch;
      if (ctl.capture)       stepCnt <= SW'(K - 2);
      else if (ctl.expShift) stepCnt <= stepCnt - 1'b1;
    end
  end
endmodule

// File: rtl/binexp_engine.sv
module binexp_engine
  import binexp_pkg::*;
#(
  parameter int K = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [K-1:0] baseIn,
  input  logic [K-1:0] expIn,
  input  logic [K-1:0] modIn,
  output logic         busy,
  output logic         done,
  output logic [K-1:0] result,
  output logic         err
);
  dpCtl_t       ctl;
  logic         modZeroIn, modOneIn, curBit, mulDone;
  logic [K-1:0] modHeld;

  binexp_ctrl #(.K(K)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .modZeroIn(modZeroIn), .modOneIn(modOneIn),
    .curBit(curBit), .mulDone(mulDone),
    .ctl(ctl), .busy(busy), .done(done)
  );

  binexp_dp #(.K(K)) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl),
    .baseIn(baseIn), .expIn(expIn), .modIn(modIn),
    .modZeroIn(modZeroIn), .modOneIn(modOneIn),
    .curBit(curBit), .mulDone(mulDone),
    .result(result), .modHeld(modHeld), .err(err)
  );
endmodule

// File: rtl/binexp_chk.sv
module binexp_chk #(
  parameter int K = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [K-1:0] result,
  input logic         err,
  input logic [K-1:0] modHeld
);
  // R5: an accepted start makes the engine busy next cycle
  p_busy_after_start_r5: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  // R6: completion pulse lasts one cycle and comes with busy low
  p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  p_result_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));

  // R9: zero modulus reports error with a zero result
  p_err_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> (result == '0));

  // R12: a good result is always reduced below the modulus
  p_reduced_r12: assert property (@(posedge clk) disable iff (rst)
    (done && !err) |-> (result < modHeld));
endmodule

bind binexp_engine binexp_chk #(.K(K)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .result(result), .err(err), .modHeld(modHeld)
);

// File: tb/sim_binexp_engine.sv
`timescale 1ns/1ps
module sim_binexp_engine;
  localparam int K = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [K-1:0] baseIn = '0, expIn = '0, modIn = '0;
  logic         busy, done, err;
  logic [K-1:0] result;

  int nTests = 0;
  int nFail  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  binexp_engine #(.K(K)) u0 (
    .clk(clk), .rst(rst), .start(start),
    .baseIn(baseIn), .expIn(expIn), .modIn(modIn),
    .busy(busy), .done(done), .result(result), .err(err)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint refPow(input longint m, input longint e, input longint n);
    longint r = 1 % n;
    for (longint i = 0; i < e; i++) r = (r * m) % n;
    return r;
  endfunction

  task automatic runOp(input logic [K-1:0] m, e, n,
                       output logic [K-1:0] r, output logic ef, output int cyc);
    @(negedge clk);
    baseIn = m; expIn = e; modIn = n; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    if (!done) chk(1'b0, "watchdog-run", cyc, 0);
    r = result; ef = err;
  endtask

  task automatic tReset();
    chk(busy == 0,   "R11 busy",   busy, 0);
    chk(done == 0,   "R11 done",   done, 0);
    chk(err == 0,    "R11 err",    err, 0);
    chk(result == 0, "R11 result", result, 0);
  endtask

  task automatic tVectors();
    logic [K-1:0] r; logic ef; int c;
    runOp(16'd123, 16'd17, 16'd3233, r, ef, c);
    chk(r == 855, "R1 encrypt", r, 855);
    runOp(16'd855, 16'd2753, 16'd3233, r, ef, c);
    chk(r == 123, "R1 decrypt", r, 123);
  endtask

  task automatic tEdgeExps();
    logic [K-1:0] r; logic ef; int c;
    longint ex;
    runOp(16'd45, 16'd0, 16'd1000, r, ef, c);
    chk(r == 1, "R2 e=0", r, 1);
    runOp(16'd45, 16'd1, 16'd1000, r, ef, c);
    chk(r == 45, "R2 e=1", r, 45);
    ex = refPow(7, 32768, 60013);
    runOp(16'd7, 16'h8000, 16'd60013, r, ef, c);
    chk(r == ex, "R2 top bit only", r, ex);
    ex = refPow(7, 123, 9973);
    runOp(16'd7, 16'd123, 16'd9973, r, ef, c);
    chk(r == ex, "R3 exp 123", r, ex);
  endtask

  task automatic tRandom();
    logic [K-1:0] r; logic ef; int c;
    for (int i = 0; i < 12; i++) begin
      longint n = ($urandom % 65534) + 2;
      longint m = $urandom % n;
      longint e = $urandom % 65536;
      longint ex = refPow(m, e, n);
      runOp(K'(m), K'(e), K'(n), r, ef, c);
      chk(r == ex, "R1 random", r, ex);
      chk(r < n && !ef, "R12 reduced", r, n - 1);
    end
  endtask

  task automatic tLatency();
    logic [K-1:0] r; logic ef; int c1, c2, c3, c4;
    runOp(16'd5, 16'h8003, 16'd9973, r, ef, c1);
    runOp(16'd5, 16'h0300, 16'd9973, r, ef, c2);
    chk(c1 == c2, "R4 same popcount", c2, c1);
    runOp(16'd5, 16'h7FFF, 16'd9973, r, ef, c3);
    runOp(16'd5, 16'hFFFF, 16'd9973, r, ef, c4);
    chk(c3 == c4, "R4 all ones", c4, c3);
    chk(c3 > c1, "R4 more multiplies", c3, c1);
  endtask

  task automatic tProtocol();
    logic [K-1:0] held; int cyc;
    @(negedge clk);
    baseIn = 16'd9; expIn = 16'd300; modIn = 16'd1009; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1, "R5 busy after start", busy, 1);
    cyc = 0;
    while (!done && cyc < 20000) begin
      chk(busy == 1, "R5 busy held", busy, 1);
      @(negedge clk); cyc++;
    end
    chk(busy == 0, "R6 busy low at done", busy, 0);
    held = result;
    chk(held == refPow(9, 300, 1009), "R1 protocol run", held, refPow(9, 300, 1009));
    @(negedge clk);
    chk(done == 0, "R6 done one cycle", done, 0);
    chk(result == held, "R6 result held", result, held);
  endtask

  task automatic tIgnore();
    int cyc; int extra;
    longint ex = refPow(11, 4000, 30011);
    @(negedge clk);
    baseIn = 16'd11; expIn = 16'd4000; modIn = 16'd30011; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    baseIn = 16'd3; expIn = 16'd5; modIn = 16'd7; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    baseIn = 16'd2; expIn = 16'd9; modIn = 16'd0;
    cyc = 0;
    while (!done && cyc < 20000) begin @(negedge clk); cyc++; end
    chk(result == ex, "R7 R10 result unaffected", result, ex);
    chk(err == 0, "R10 modulus change ignored", err, 0);
    extra = 0;
    repeat (60) begin @(negedge clk); if (done) extra++; end
    chk(extra == 0, "R7 no extra done", extra, 0);
  endtask

  task automatic tDegenerate();
    logic [K-1:0] r; logic ef; int c;
    runOp(16'd0, 16'd77, 16'd1, r, ef, c);
    chk(r == 0 && ef == 0, "R8 modulus one", r, 0);
    runOp(16'd4, 16'd77, 16'd0, r, ef, c);
    chk(ef == 1, "R9 err set", ef, 1);
    chk(r == 0, "R9 zero result", r, 0);
    chk(c <= 2, "R9 no iteration", c, 2);
    runOp(16'd4, 16'd3, 16'd10, r, ef, c);
    chk(ef == 0 && r == 4, "R9 err cleared", r, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    tReset();
    tVectors();
    tEdgeExps();
    tRandom();
    tLatency();
    tProtocol();
    tIgnore();
    tDegenerate();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #3_900_000;
    if (!finished) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule